// File: doc/BRIEF.md
# Four-Function ALU with Condition Flags

This block is the arithmetic/logic unit of a small 32-bit processor datapath. It takes two data words and a two-bit function code and returns a result word and three condition flags: signed overflow, zero and carry. It supports four operations: addition, subtraction, bitwise AND and bitwise XOR.

The unit has no clock and holds no state. Its outputs are pure functions of its present inputs and follow any change on the operands or the function code. The flags are produced on every cycle for every operation. A surrounding pipeline decides whether and when to capture them in a flag register, and that register is not part of this block.

Top module: `alu_cc_core`

## Requirements
- R1: The outputs depend only on the current inputs. After any change of `opnd_a`, `opnd_b` or `func`, the outputs settle to the new function value with no clock edge.
- R2: With `func` = 2'd0, `result` equals `opnd_a + opnd_b` modulo 2^32.
- R3: With `func` = 2'd1, `result` equals `opnd_b - opnd_a` modulo 2^32. The first operand is subtracted from the second.
- R4: With `func` = 2'd2, `result` equals `opnd_a & opnd_b`.
- R5: With `func` = 2'd3, `result` equals `opnd_a ^ opnd_b`.
- R6: `zero` is 1 exactly when all 32 bits of `result` are 0. This holds for all four function codes.
- R7: For codes 0 and 1, `ovf` is 1 exactly when the true signed two's-complement result does not fit in 32 bits.
- R8: For code 0, `carry` is the carry out of bit 31. For code 1, `carry` is 1 exactly when `opnd_a` is greater than `opnd_b` as unsigned numbers, which is the borrow.
- R9: For codes 2 and 3, `ovf` and `carry` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First operand; the subtrahend for subtraction |
| opnd_b | input | 32 | Second operand; the minuend for subtraction |
| func | input | 2 | Function code: 0 add, 1 subtract, 2 AND, 3 XOR |
| result | output | 32 | Result word |
| ovf | output | 1 | Signed overflow flag |
| zero | output | 1 | Result-is-zero flag |
| carry | output | 1 | Carry out (add) or borrow (subtract) |

## Verification
The assertions assume fully known inputs. They evaluate only when no bit of the operands or the function code is X or Z, because the relations they check mean nothing on unknown values. The stimulus always drives all inputs to defined values, starting from all zeros at time zero. It waits a short settling delay after each change before it samples, so every check sees a stable input set. The directed operands sit on the signed and unsigned boundaries: 0, 1, all ones, the largest positive value and the most negative value. Random operands cover the rest of the space under every function code.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

    localparam int unsigned DATA_W = 32;

    typedef enum logic [1:0] {
        FN_ADD = 2'd0,
        FN_SUB = 2'd1,
        FN_AND = 2'd2,
        FN_XOR = 2'd3
    } alu_fn_e;

    typedef struct packed {
        logic ovf;
        logic zero;
        logic carry;
    } alu_flags_t;

endpackage

// File: rtl/alu_cc_addsub.sv
// Shared adder: computes x + y (+1) where y is the first operand,
// inverted when subtracting, so one carry chain serves both operations.
module alu_cc_addsub #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] src_x,
    input  logic [W-1:0] src_y,
    input  logic         do_sub,
    output logic [W-1:0] sum,
    output logic         carry_out,
    output logic         sgn_ovf
);
    localparam int unsigned MSB = W - 1;

    logic [W-1:0] y_eff;
    logic [W:0]   wide_sum;

    always_comb begin
        y_eff     = do_sub ? ~src_y : src_y;
        wide_sum  = {1'b0, src_x} + {1'b0, y_eff} + {{W{1'b0}}, do_sub};
        sum       = wide_sum[W-1:0];
        carry_out = wide_sum[W];
        sgn_ovf   = (src_x[MSB] == y_eff[MSB]) && (wide_sum[MSB] != src_x[MSB]);
    end
endmodule

// File: rtl/alu_cc_logic.sv
module alu_cc_logic #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] src_a,
    input  logic [W-1:0] src_b,
    input  logic         pick_xor,
    output logic [W-1:0] res
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            assign res[i] = pick_xor ? (src_a[i] ^ src_b[i]) : (src_a[i] & src_b[i]);
        end
    endgenerate
endmodule

// File: rtl/alu_cc_core.sv
module alu_cc_core
    import alu_cc_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [1:0]   func,
    output logic [W-1:0] result,
    output logic         ovf,
    output logic         zero,
    output logic         carry
);
    alu_fn_e      fn;
    logic [W-1:0] arith_sum;
    logic         arith_cout;
    logic         arith_ovf;
    logic [W-1:0] logic_res;
    logic [W-1:0] result_d;
    alu_flags_t   flags_d;

    assign fn = alu_fn_e'(func);

    alu_cc_addsub #(.W(W)) u_addsub (
        .src_x     (opnd_b),
        .src_y     (opnd_a),
        .do_sub    (fn == FN_SUB),
        .sum       (arith_sum),
        .carry_out (arith_cout),
        .sgn_ovf   (arith_ovf)
    );

    alu_cc_logic #(.W(W)) u_logic (
        .src_a    (opnd_a),
        .src_b    (opnd_b),
        .pick_xor (fn == FN_XOR),
        .res      (logic_res)
    );

    always_comb begin
        result_d      = logic_res;
        flags_d.ovf   = 1'b0;
        flags_d.carry = 1'b0;
        unique case (fn)
            FN_ADD: begin
                result_d      = arith_sum;
                flags_d.ovf   = arith_ovf;
                flags_d.carry = arith_cout;
            end
            FN_SUB: begin
                result_d      = arith_sum;
                flags_d.ovf   = arith_ovf;
                flags_d.carry = ~arith_cout;
            end
            default: ;
        endcase
        flags_d.zero = ~|result_d;
    end

    assign result = result_d;
    assign ovf    = flags_d.ovf;
    assign zero   = flags_d.zero;
    assign carry  = flags_d.carry;
endmodule

// File: rtl/alu_cc_core_chk.sv
module alu_cc_core_chk #(
    parameter int unsigned W = 32
) (
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic [1:0]   func,
    input logic [W-1:0] result,
    input logic         ovf,
    input logic         zero,
    input logic         carry
);
    logic known;
    assign known = !$isunknown({opnd_a, opnd_b, func});

    always_comb begin
        if (known) begin
            if (func == 2'd0)
                assert_add_inverse_R2: assert (result - opnd_a == opnd_b);
            if (func == 2'd1)
                assert_sub_inverse_R3: assert (result + opnd_a == opnd_b);
            if (func == 2'd2)
                assert_and_subset_R4: assert ((result & ~(opnd_a & opnd_b)) == '0 && (result | ~opnd_a) == '1 ? 1'b1 : (result & ~opnd_a) == '0);
            if (func == 2'd3)
                assert_xor_undo_R5: assert ((result ^ opnd_b) == opnd_a);
            assert_zero_flag_R6: assert (zero == (result == '0));
            if (func[1])
                assert_no_flags_R9: assert (!ovf && !carry);
            if (func == 2'd0 && opnd_a[W-1] != opnd_b[W-1])
                assert_no_overflow_R7: assert (!ovf);
            if (func == 2'd1 && opnd_a == opnd_b)
                assert_no_borrow_R8: assert (!carry && zero);
        end
    end
endmodule

bind alu_cc_core alu_cc_core_chk #(.W(W)) u_chk (
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .func   (func),
    .result (result),
    .ovf    (ovf),
    .zero   (zero),
    .carry  (carry)
);

// File: tb/alu_cc_core_bench.sv
module alu_cc_core_bench;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic [1:0]   func = 2'd0;
    logic [W-1:0] result;
    logic         ovf, zero, carry;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    alu_cc_core u_alu_cc_core (
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .func   (func),
        .result (result),
        .ovf    (ovf),
        .zero   (zero),
        .carry  (carry)
    );

    task automatic chk(input string req, input logic [W+2:0] act, input logic [W+2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h (a=%h b=%h fn=%0d)",
                     req, act, exp, opnd_a, opnd_b, func);
        end
    endtask

    // Reference model from the requirements; returns {result, ovf, zero, carry}.
    function automatic logic [W+2:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                           input logic [1:0] f);
        logic [W-1:0] r;
        logic o, c;
        longint sa, sb, sr;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        o = 1'b0;
        c = 1'b0;
        case (f)
            2'd0: begin
                r  = a + b;
                sr = sa + sb;
                o  = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
                c  = ({1'b0, a} + {1'b0, b}) > 33'h0FFFFFFFF;
            end
            2'd1: begin
                r  = b - a;
                sr = sb - sa;
                o  = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
                c  = a > b;
            end
            2'd2: r = a & b;
            default: r = a ^ b;
        endcase
        return {r, o, (r == '0), c};
    endfunction

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic [1:0] f,
                         input string req);
        opnd_a = a;
        opnd_b = b;
        func   = f;
        #2;
        chk(req, {result, ovf, zero, carry}, model(a, b, f));
    endtask

    task automatic t_reset_state;
        #2;
        // R2 R6: all-zero inputs with add give zero result and zero flag set
        chk("R2/R6 initial", {result, ovf, zero, carry}, {{W{1'b0}}, 3'b010});
    endtask

    task automatic t_add;
        apply(32'd5, 32'd7, 2'd0, "R2 add");
        apply(32'hFFFFFFFF, 32'd1, 2'd0, "R8 add carry wrap to zero");
        apply(32'h7FFFFFFF, 32'd1, 2'd0, "R7 add positive overflow");
        apply(32'h80000000, 32'h80000000, 2'd0, "R7 R8 add negative overflow");
        apply(32'h80000000, 32'h7FFFFFFF, 2'd0, "R7 add mixed signs");
    endtask

    task automatic t_sub;
        apply(32'd3, 32'd10, 2'd1, "R3 sub b-a");
        apply(32'd10, 32'd3, 2'd1, "R8 sub borrow");
        apply(32'h12345678, 32'h12345678, 2'd1, "R6 sub equal");
        apply(32'd1, 32'h80000000, 2'd1, "R7 sub negative overflow");
        apply(32'h80000000, 32'd0, 2'd1, "R7 sub most-negative");
    endtask

    task automatic t_logic;
        apply(32'hF0F0_FFFF, 32'hFF00_0F0F, 2'd2, "R4 and");
        apply(32'hAAAA_AAAA, 32'h5555_5555, 2'd2, "R4 R6 and disjoint");
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd2, "R9 and all ones");
        apply(32'h1234_5678, 32'hFFFF_0000, 2'd3, "R5 xor");
        apply(32'hDEAD_BEEF, 32'hDEAD_BEEF, 2'd3, "R5 R6 xor self");
        apply(32'hFFFF_FFFF, 32'h8000_0000, 2'd3, "R9 xor flags clear");
    endtask

    task automatic t_comb_response;
        // R1: outputs follow a function-code change with no clock edge between
        opnd_a = 32'h0000_00F0;
        opnd_b = 32'h0000_0F0F;
        for (int f = 0; f < 4; f++) begin
            func = 2'(f);
            #1;
            chk("R1 comb follow", {result, ovf, zero, carry}, model(opnd_a, opnd_b, 2'(f)));
        end
    endtask

    task automatic t_random;
        for (int i = 0; i < 400; i++) begin
            apply($urandom, $urandom, 2'(i % 4), "R2 R3 R4 R5 R7 R8 random");
        end
    endtask

    initial begin
        t_reset_state();
        t_add();
        t_sub();
        t_logic();
        t_comb_response();
        t_random();
        done = 1'b1;
    end

    always @(posedge clk) cycles <= cycles + 1;

    initial begin
        wait (done || cycles >= 100000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule